// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked form (class, sign, unbiased exponent, significand with its leading one, guard and round bits, and a sticky bit) and forms the 32-bit binary32 word. It places the exponent bias, shifts results that are too small into the subnormal range, rounds under one of four modes, and renormalises when the rounding carries out. Results too large for the format become either infinity or the largest finite value, depending on the mode and the sign. It also raises inexact, underflow and overflow flags.

An arithmetic datapath uses it as the last stage before writeback. The core is combinational. The word and the flags are registered once, and a valid bit travels alongside them. A NaN passes through with the upper bits of its payload kept. Zeros and infinities keep their sign.

Top module: `sp_result_packer`

## Requirements
- R1: A result appears on the outputs one clock after `valid_i` is high, with `valid_o` high for that one cycle. While `valid_i` is low the word and flags hold their last value and `valid_o` is low. After reset all outputs are zero.
- R2: Class code 0 (zero) gives a word that has only the sign bit, bit 31. All flags are clear.
- R3: Class code 2 (infinity) gives the sign, exponent field 0xFF and fraction 0. All flags are clear.
- R4: Class code 3 (NaN) gives exponent field 0xFF and fraction equal to significand bits 24:2, with no rounding. All flags are clear.
- R5: Class code 1 (number) with biased exponent `exp_i`+127 in 1..254 and guard, round and sticky all clear gives that biased exponent in bits 30:23 and significand bits 24:2 in the fraction. All flags are clear.
- R6: Rounding mode code 0 is to nearest even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. Inexact is set exactly when any of guard, round or sticky is set after alignment.
- R7: In nearest-even mode, guard set with round and sticky clear is a tie. It rounds up only when the fraction LSB is odd. Guard set with sticky set always rounds up.
- R8: When a normal significand rounds up to 2.0, the exponent goes up by one and the fraction is zero.
- R9: A biased exponent of 0 or less shifts the significand right by 1 minus the biased exponent. The bits shifted out join sticky. The result is emitted with exponent field 0, and underflow is set if the result is inexact or if `uf_trap_en_i` is high.
- R10: A subnormal that rounds up to 1<<23 is emitted as the smallest normal, 0x00800000 with the sign. Underflow stays clear even with the trap enable high.
- R11: A shift of 26 or more moves every significand bit into sticky. The result is then zero, or the smallest subnormal when the mode rounds away from zero.
- R12: A final biased exponent of 255 or more gives infinity with `ovf_o` set under mode 0, under mode 2 when positive, or under mode 3 when negative. Otherwise it gives exponent 0xFE with an all-ones fraction and `ovf_o` clear. Inexact reflects only the rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input result valid |
| cls_i | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_i | input | 1 | Sign |
| exp_i | input | 10 | Unbiased exponent, two's complement |
| sig_i | input | 26 | Leading one, 23 fraction bits, guard, round |
| sticky_i | input | 1 | OR of all bits below round |
| rmode_i | input | 2 | Rounding mode code |
| uf_trap_en_i | input | 1 | Underflow trap enable |
| valid_o | output | 1 | Output valid |
| word_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Rounding lost information |
| underflow_o | output | 1 | Tiny result signalled |
| ovf_o | output | 1 | Overflow to infinity |

## Verification
Exact normals are checked first, so that exponent biasing and fraction placement are confirmed without any rounding in play. The same inexact operand is then run through all four modes with both signs, which separates the directed modes from one another. Even and odd ties, with and without sticky, separate a true round-to-nearest-even from a plain round-half-up. The subnormal cases cover an exact shift, a tie after the shift, a carry into the smallest normal with and without the trap enable, the smallest exact subnormal, and a shift that goes past the significand width; together they test the shift count, how sticky is gathered and how underflow is suppressed. The overflow cases use an exponent just past the range and a carry out of the largest finite value, under every mode and sign choice that selects between infinity and the largest finite value.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;
endpackage

// File: rtl/sp_rshift_sticky.sv
// Right shift with sticky collection, log-depth stages.
module sp_rshift_sticky #(
  parameter int W    = 26,
  parameter int SA_W = 5
) (
  input  logic [W-1:0]    d_i,
  input  logic            st_i,
  input  logic [SA_W-1:0] amt_i,
  output logic [W-1:0]    d_o,
  output logic            st_o
);
  logic [W-1:0] stg_d [SA_W+1];
  logic         stg_s [SA_W+1];

  assign stg_d[0] = d_i;
  assign stg_s[0] = st_i;

  for (genvar i = 0; i < SA_W; i++) begin : g_stage
    localparam int SH = 1 << i;
    logic [W-1:0] shifted;
    logic         lost;
    if (SH >= W) begin : g_all
      assign shifted = '0;
      assign lost    = |stg_d[i];
    end else begin : g_part
      assign shifted = stg_d[i] >> SH;
      assign lost    = |stg_d[i][SH-1:0];
    end
    assign stg_d[i+1] = amt_i[i] ? shifted : stg_d[i];
    assign stg_s[i+1] = stg_s[i] | (amt_i[i] & lost);
  end

  assign d_o  = stg_d[SA_W];
  assign st_o = stg_s[SA_W];
endmodule

// File: rtl/sp_rounder.sv
module sp_rounder
  import sp_pack_pkg::*;
#(
  parameter int MW = 24
) (
  input  logic [MW-1:0] man_i,
  input  logic [1:0]    gr_i,
  input  logic          st_i,
  input  logic          sign_i,
  input  rmode_e        mode_i,
  output logic [MW:0]   man_o,
  output logic          inexact_o
);
  logic up;

  assign inexact_o = (|gr_i) | st_i;

  always_comb begin
    up = 1'b0;
    if (inexact_o) begin
      unique case (mode_i)
        RM_NEAR: up = gr_i[1] & (gr_i[0] | st_i | man_i[0]);
        RM_ZERO: up = 1'b0;
        RM_UP:   up = ~sign_i;
        RM_DOWN: up = sign_i;
        default: up = 1'b0;
      endcase
    end
  end

  assign man_o = {1'b0, man_i} + {{MW{1'b0}}, up};
endmodule

// File: rtl/sp_ovf_select.sv
// Decides whether an out-of-range result saturates to infinity.
module sp_ovf_select
  import sp_pack_pkg::*;
(
  input  logic   sign_i,
  input  rmode_e mode_i,
  output logic   to_inf_o
);
  always_comb begin
    unique case (mode_i)
      RM_NEAR: to_inf_o = 1'b1;
      RM_ZERO: to_inf_o = 1'b0;
      RM_UP:   to_inf_o = ~sign_i;
      RM_DOWN: to_inf_o = sign_i;
      default: to_inf_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int FRAC_W = 23,
  parameter int EF_W   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              cls_i,
  input  logic                    sign_i,
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [FRAC_W+2:0]       sig_i,
  input  logic                    sticky_i,
  input  logic [1:0]              rmode_i,
  input  logic                    uf_trap_en_i,
  output logic                    valid_o,
  output logic [FRAC_W+EF_W:0]    word_o,
  output logic                    inexact_o,
  output logic                    underflow_o,
  output logic                    ovf_o
);
  localparam int MW    = FRAC_W + 1;
  localparam int SIG_W = MW + 2;
  localparam int WW    = 1 + EF_W + FRAC_W;
  localparam int BW    = EXP_W + 2;
  localparam int SA_W  = $clog2(SIG_W + 1);
  localparam int BIAS  = (1 << (EF_W - 1)) - 1;
  localparam int EMAX  = (1 << EF_W) - 1;

  cls_e   cls;
  rmode_e mode;
  assign cls  = cls_e'(cls_i);
  assign mode = rmode_e'(rmode_i);

  // exponent bias and subnormal shift count
  logic signed [BW-1:0] biased, deficit, exp_fin;
  logic                 is_sub;
  logic [SA_W-1:0]      sh_amt;

  assign biased  = $signed({{2{exp_i[EXP_W-1]}}, exp_i}) + BW'(BIAS);
  assign is_sub  = (biased <= BW'(0));
  assign deficit = BW'(1) - biased;

  always_comb begin
    if (!is_sub)                    sh_amt = '0;
    else if (deficit > BW'(SIG_W))  sh_amt = SA_W'(SIG_W);
    else                            sh_amt = SA_W'(deficit);
  end

  logic [SIG_W-1:0] sh_sig;
  logic             sh_st;

  sp_rshift_sticky #(.W(SIG_W), .SA_W(SA_W)) u_shift (
    .d_i   (sig_i),
    .st_i  (sticky_i),
    .amt_i (sh_amt),
    .d_o   (sh_sig),
    .st_o  (sh_st)
  );

  logic [MW:0] rnd;
  logic        rnd_ix;

  sp_rounder #(.MW(MW)) u_round (
    .man_i     (sh_sig[SIG_W-1:2]),
    .gr_i      (sh_sig[1:0]),
    .st_i      (sh_st),
    .sign_i    (sign_i),
    .mode_i    (mode),
    .man_o     (rnd),
    .inexact_o (rnd_ix)
  );

  logic to_inf;

  sp_ovf_select u_ovf (
    .sign_i   (sign_i),
    .mode_i   (mode),
    .to_inf_o (to_inf)
  );

  // carry out of rounding renormalises by one
  assign exp_fin = biased + $signed({{(BW-1){1'b0}}, rnd[MW]});

  logic [WW-1:0] word_d;
  logic          ix_d, uf_d, of_d;

  always_comb begin
    word_d = '0;
    ix_d   = 1'b0;
    uf_d   = 1'b0;
    of_d   = 1'b0;
    unique case (cls)
      CLS_ZERO: word_d = {sign_i, {(WW-1){1'b0}}};
      CLS_INF:  word_d = {sign_i, {EF_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_NAN:  word_d = {sign_i, {EF_W{1'b1}}, sig_i[SIG_W-2:2]};
      default: begin
        ix_d = rnd_ix;
        if (is_sub) begin
          if (rnd[MW-1]) begin
            word_d = {sign_i, {(EF_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
          end else begin
            word_d = {sign_i, {EF_W{1'b0}}, rnd[FRAC_W-1:0]};
            uf_d   = rnd_ix | uf_trap_en_i;
          end
        end else if (exp_fin >= BW'(EMAX)) begin
          if (to_inf) begin
            word_d = {sign_i, {EF_W{1'b1}}, {FRAC_W{1'b0}}};
            of_d   = 1'b1;
          end else begin
            word_d = {sign_i, {(EF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
          end
        end else begin
          word_d = {sign_i, exp_fin[EF_W-1:0], rnd[FRAC_W-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      word_o      <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        word_o      <= word_d;
        inexact_o   <= ix_d;
        underflow_o <= uf_d;
        ovf_o       <= of_d;
      end
    end
  end
endmodule

// File: rtl/sp_result_packer_chk.sv
module sp_result_packer_chk #(
  parameter int FRAC_W = 23,
  parameter int EF_W   = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [1:0]           cls_i,
  input logic [FRAC_W+2:0]    sig_i,
  input logic                 valid_o,
  input logic [FRAC_W+EF_W:0] word_o,
  input logic                 inexact_o,
  input logic                 underflow_o,
  input logic                 ovf_o
);
  localparam int WW = 1 + EF_W + FRAC_W;

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(word_o))); // R1
  AST_ZERO_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 2'd0) |=> (word_o[WW-2:0] == '0 && !inexact_o)); // R2
  AST_NAN_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 2'd3) |=> (word_o[WW-2:FRAC_W] == {EF_W{1'b1}}
      && word_o[FRAC_W-1:0] == $past(sig_i[FRAC_W+1:2]))); // R4
  AST_UF_TINY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (word_o[WW-2:FRAC_W] == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (word_o[WW-2:0] == {{EF_W{1'b1}}, {FRAC_W{1'b0}}})); // R12
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && underflow_o)); // R12
endmodule

bind sp_result_packer sp_result_packer_chk #(.FRAC_W(FRAC_W), .EF_W(EF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .cls_i       (cls_i),
  .sig_i       (sig_i),
  .valid_o     (valid_o),
  .word_o      (word_o),
  .inexact_o   (inexact_o),
  .underflow_o (underflow_o),
  .ovf_o       (ovf_o)
);

// File: tb/sp_result_packer_tb.sv
module sp_result_packer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  cls_i = '0;
  logic        sign_i = 1'b0;
  logic [9:0]  exp_i = '0;
  logic [25:0] sig_i = '0;
  logic        sticky_i = 1'b0;
  logic [1:0]  rmode_i = '0;
  logic        uf_trap_en_i = 1'b0;
  logic        valid_o;
  logic [31:0] word_o;
  logic        inexact_o, underflow_o, ovf_o;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  sp_result_packer u_dut (
    .clk_i, .rst_ni, .valid_i, .cls_i, .sign_i, .exp_i, .sig_i, .sticky_i,
    .rmode_i, .uf_trap_en_i, .valid_o, .word_o, .inexact_o, .underflow_o, .ovf_o
  );

  task automatic check(input string req, input logic [31:0] w, input logic ix,
                       input logic uf, input logic of);
    checks++;
    if (word_o !== w || inexact_o !== ix || underflow_o !== uf || ovf_o !== of
        || valid_o !== 1'b1) begin
      bad++;
      $display("FAIL %s: got word=%08h ix=%0b uf=%0b of=%0b v=%0b exp word=%08h ix=%0b uf=%0b of=%0b v=1",
               req, word_o, inexact_o, underflow_o, ovf_o, valid_o, w, ix, uf, of);
    end
  endtask

  task automatic run(input string req, input logic [1:0] cls, input logic sg,
                     input int e, input logic [22:0] frac, input logic [1:0] gr,
                     input logic st, input logic [1:0] md, input logic trap,
                     input logic [31:0] w, input logic ix, input logic uf, input logic of);
    @(negedge clk_i);
    valid_i = 1'b1; cls_i = cls; sign_i = sg; exp_i = 10'(e);
    sig_i = {1'b1, frac, gr}; sticky_i = st; rmode_i = md; uf_trap_en_i = trap;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, w, ix, uf, of);
  endtask

  task automatic t_reset();
    checks++;
    if (valid_o !== 1'b0 || word_o !== 32'h0 || inexact_o || underflow_o || ovf_o) begin
      bad++;
      $display("FAIL R1 reset: got v=%0b word=%08h exp v=0 word=00000000", valid_o, word_o);
    end
  endtask

  task automatic t_specials();
    run("R2 neg zero", 2'd0, 1, 0, 23'h0, 2'b11, 1, 2'd0, 1, 32'h8000_0000, 0, 0, 0);
    run("R3 pos inf", 2'd2, 0, 0, 23'h0, 2'b00, 0, 2'd0, 0, 32'h7F80_0000, 0, 0, 0);
    run("R4 nan", 2'd3, 1, 0, 23'h400123, 2'b11, 1, 2'd0, 0, 32'hFFC0_0123, 0, 0, 0);
  endtask

  task automatic t_normal();
    run("R5 exact", 2'd1, 0, 0, 23'h123456, 2'b00, 0, 2'd0, 0, 32'h3F92_3456, 0, 0, 0);
    run("R5 top", 2'd1, 0, 127, 23'h7FFFFF, 2'b00, 0, 2'd0, 0, 32'h7F7F_FFFF, 0, 0, 0);
  endtask

  task automatic t_modes();
    run("R6 near", 2'd1, 0, 1, 23'h1, 2'b01, 0, 2'd0, 0, 32'h4000_0001, 1, 0, 0);
    run("R6 zero", 2'd1, 0, 1, 23'h1, 2'b01, 0, 2'd1, 0, 32'h4000_0001, 1, 0, 0);
    run("R6 up", 2'd1, 0, 1, 23'h1, 2'b01, 0, 2'd2, 0, 32'h4000_0002, 1, 0, 0);
    run("R6 down pos", 2'd1, 0, 1, 23'h1, 2'b01, 0, 2'd3, 0, 32'h4000_0001, 1, 0, 0);
    run("R6 down neg", 2'd1, 1, 1, 23'h1, 2'b01, 0, 2'd3, 0, 32'hC000_0002, 1, 0, 0);
    run("R6 up neg", 2'd1, 1, 1, 23'h1, 2'b01, 0, 2'd2, 0, 32'hC000_0001, 1, 0, 0);
  endtask

  task automatic t_ties();
    run("R7 tie even", 2'd1, 0, 0, 23'h2, 2'b10, 0, 2'd0, 0, 32'h3F80_0002, 1, 0, 0);
    run("R7 tie odd", 2'd1, 0, 0, 23'h3, 2'b10, 0, 2'd0, 0, 32'h3F80_0004, 1, 0, 0);
    run("R7 sticky", 2'd1, 0, 0, 23'h2, 2'b10, 1, 2'd0, 0, 32'h3F80_0003, 1, 0, 0);
  endtask

  task automatic t_carry();
    run("R8 carry", 2'd1, 0, 0, 23'h7FFFFF, 2'b10, 0, 2'd0, 0, 32'h4000_0000, 1, 0, 0);
  endtask

  task automatic t_subnormal();
    run("R9 exact", 2'd1, 0, -127, 23'h2, 2'b00, 0, 2'd0, 0, 32'h0040_0001, 0, 0, 0);
    run("R9 trap", 2'd1, 0, -127, 23'h2, 2'b00, 0, 2'd0, 1, 32'h0040_0001, 0, 1, 0);
    run("R9 tie", 2'd1, 0, -127, 23'h1, 2'b00, 0, 2'd0, 0, 32'h0040_0000, 1, 1, 0);
    run("R10 min normal", 2'd1, 0, -127, 23'h7FFFFF, 2'b10, 0, 2'd0, 0, 32'h0080_0000, 1, 0, 0);
    run("R10 min normal trap", 2'd1, 1, -127, 23'h7FFFFF, 2'b10, 0, 2'd0, 1, 32'h8080_0000, 1, 0, 0);
    run("R11 smallest exact", 2'd1, 0, -149, 23'h0, 2'b00, 0, 2'd0, 0, 32'h0000_0001, 0, 0, 0);
    run("R11 deep near", 2'd1, 0, -200, 23'h0, 2'b00, 0, 2'd0, 0, 32'h0000_0000, 1, 1, 0);
    run("R11 deep up", 2'd1, 0, -200, 23'h0, 2'b00, 0, 2'd2, 0, 32'h0000_0001, 1, 1, 0);
    run("R11 deep down neg", 2'd1, 1, -200, 23'h0, 2'b00, 0, 2'd3, 0, 32'h8000_0001, 1, 1, 0);
  endtask

  task automatic t_overflow();
    run("R12 near", 2'd1, 0, 128, 23'h0, 2'b00, 0, 2'd0, 0, 32'h7F80_0000, 0, 0, 1);
    run("R12 zero", 2'd1, 0, 128, 23'h0, 2'b00, 0, 2'd1, 0, 32'h7F7F_FFFF, 0, 0, 0);
    run("R12 up neg", 2'd1, 1, 128, 23'h0, 2'b00, 0, 2'd2, 0, 32'hFF7F_FFFF, 0, 0, 0);
    run("R12 down neg", 2'd1, 1, 128, 23'h0, 2'b00, 0, 2'd3, 0, 32'hFF80_0000, 0, 0, 1);
    run("R12 carry", 2'd1, 0, 127, 23'h7FFFFF, 2'b10, 0, 2'd0, 0, 32'h7F80_0000, 1, 0, 1);
  endtask

  task automatic t_hold();
    run("R1 load", 2'd1, 0, 0, 23'h55, 2'b00, 0, 2'd0, 0, 32'h3F80_0055, 0, 0, 0);
    @(negedge clk_i);
    cls_i = 2'd2; sign_i = 1'b1;
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || word_o !== 32'h3F80_0055) begin
      bad++;
      $display("FAIL R1 hold: got v=%0b word=%08h exp v=0 word=3f800055", valid_o, word_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_specials();
    t_normal();
    t_modes();
    t_ties();
    t_carry();
    t_subnormal();
    t_overflow();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule